// File: doc/BRIEF.md
# Multithreaded Parent-Set Scoring Core

This core scores one network node against a local order. The local order is a mask with one bit per node, and a set bit means that node may act as a parent. After a start pulse, a stream of candidates arrives, one per clock. Each candidate pairs a parent mask with a signed local score. A candidate whose parents all lie inside the local order contributes to three results. The order score is a log-domain sum of the candidate scores. The graph score is the largest candidate score. The best parent mask is the mask that produced that largest score. A candidate that fails the test is predicated off and has no effect.

Candidates are dealt round-robin over THREADS thread accumulators, so each accumulator is updated at most once per clock. When a local order's last candidate arrives, the thread partials are copied into a reduction bank and the accumulators are cleared. While the next local order is being scored, a reducer folds the bank one thread per cycle. It then folds in the partial result received from the upstream core on the chain input. The final result is presented once, with a done pulse, on a bus that can feed the chain input of the next core.

Top module: `parent_score_core`

## Requirements
- R1: A candidate counts only when its parent mask has no bit set outside the local order mask, that is (parents & ~order) == 0. The empty parent set always counts. A candidate that fails the test changes none of the three results.
- R2: When no candidate counts and the chain partial is marked empty, the result has out_empty = 1.
- R3: Candidate i of a local order, counted from 0, goes to thread i mod THREADS. Two partials a and b merge as follows. The order score is max(a,b) + c, where d = |a-b| and c = 0 when d >= 2*CORR_MAX, otherwise c = CORR_MAX - floor(d/2). The default CORR_MAX is 8. An empty partial merged with x gives x. Each thread merges its candidates in arrival order. The result merges threads 0 to THREADS-1 in turn, then merges the chain partial last.
- R4: The graph score is the largest counted score, and out_parents is its mask. On a tie, the partial merged earlier is kept: the earlier candidate within a thread, or the lower thread. The order score of a non-empty result is never below its graph score.
- R5: While a local order is open and no stall applies, in_ready stays high, and one candidate is accepted on every clock.
- R6: If the chain partial is already held, out_done rises exactly THREADS+2 clock edges after the edge that accepts the last candidate. out_done is a single-cycle pulse.
- R7: A new local order can start, and its non-last candidates can be accepted, while the previous order is still being reduced.
- R8: A candidate marked last sees in_ready low while the reduction bank is still occupied by the previous order.
- R9: The chain input is captured when chain_in_valid is high and merged after the thread reduction. out_done waits until the chain partial has been captured.
- R10: After a synchronous reset, in_ready and out_done are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a local order and loads order_mask |
| order_mask | input | 64 | Nodes allowed as parents |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate accepted this cycle when in_valid is high |
| in_last | input | 1 | Marks the last candidate of the local order |
| in_parents | input | 64 | Candidate parent mask |
| in_score | input | 16 | Candidate local score, signed |
| chain_in_valid | input | 1 | Upstream partial present (one pulse per order) |
| chain_in_empty | input | 1 | Upstream partial holds nothing |
| chain_in_order | input | 16 | Upstream order score, signed |
| chain_in_graph | input | 16 | Upstream graph score, signed |
| chain_in_parents | input | 64 | Upstream best parent mask |
| out_done | output | 1 | Result pulse, also the chain output valid |
| out_empty | output | 1 | Result holds nothing |
| out_order | output | 16 | Order score, signed |
| out_graph | output | 16 | Graph score, signed |
| out_parents | output | 64 | Best parent mask |

## Verification
One mixed order interleaves compatible candidates with high-scoring incompatible ones. A faulty filter therefore shows up in both the maximum and the log-domain sum. The scores are spread across threads so that the merge order and the correction term can be told apart. Orders with no counted candidate are run with both an empty and a non-empty upstream partial, which separates the empty flag from the chain merge. Back-to-back orders are run both with a long follower and with a single-candidate follower. The first shows that the reduction overlaps the next order, and the second shows that the last-candidate stall holds. Equal scores placed in different threads and in the same thread expose the tie rule.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int MASK_W  = 64;
  localparam int SCORE_W = 16;

  typedef logic signed [SCORE_W-1:0] score_t;
  typedef logic [MASK_W-1:0]         mask_t;

  typedef struct packed {
    logic   full;
    score_t osc;
    score_t gsc;
    mask_t  pm;
  } part_t;

  localparam part_t PART_EMPTY = '0;

  // merge two partials: log-domain sum with piecewise-linear correction, max with tie kept in a
  function automatic part_t merge(part_t a, part_t b, int unsigned cmax);
    part_t r;
    logic signed [SCORE_W:0] ea, eb, dif;
    logic [SCORE_W:0] mag, cm, corr;
    ea   = {a.osc[SCORE_W-1], a.osc};
    eb   = {b.osc[SCORE_W-1], b.osc};
    dif  = ea - eb;
    mag  = dif[SCORE_W] ? $unsigned(eb - ea) : $unsigned(dif);
    cm   = (SCORE_W+1)'(cmax);
    corr = (mag >= (cm << 1)) ? '0 : (cm - (mag >> 1));
    r.full = 1'b1;
    r.osc  = (dif[SCORE_W] ? b.osc : a.osc) + $signed(corr[SCORE_W-1:0]);
    if (b.gsc > a.gsc) begin
      r.gsc = b.gsc;
      r.pm  = b.pm;
    end else begin
      r.gsc = a.gsc;
      r.pm  = a.pm;
    end
    if (!b.full)      r = a;
    else if (!a.full) r = b;
    return r;
  endfunction
endpackage

// File: rtl/psc_filter.sv
module psc_filter
  import psc_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int IDX_W  = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  mask_t            order_q,
  input  logic             take,
  input  logic             last,
  input  mask_t            parents,
  input  score_t           score,
  input  logic [IDX_W-1:0] tid,
  output logic             s1_valid,
  output logic             s1_hit,
  output logic             s1_last,
  output logic [IDX_W-1:0] s1_tid,
  output part_t            s1_elem
);
  logic hit_c;
  assign hit_c = ~|(parents & ~order_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= take;
      s1_last  <= take & last;
    end
    if (take) begin
      s1_hit  <= hit_c;
      s1_tid  <= tid;
      s1_elem <= '{full: 1'b1, osc: score, gsc: score, pm: parents};
    end
  end
endmodule

// File: rtl/psc_threads.sv
module psc_threads
  import psc_pkg::*;
#(
  parameter int THREADS       = 4,
  parameter int unsigned CORR_MAX = 8,
  localparam int IDX_W        = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic             s1_hit,
  input  logic             s1_last,
  input  logic [IDX_W-1:0] s1_tid,
  input  part_t            s1_elem,
  output part_t            bank_o [THREADS],
  output logic             bank_load
);
  logic close_c;
  assign close_c = s1_valid & s1_last;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    part_t acc_q, bank_q, nxt_c;
    logic  upd_c;
    assign upd_c = s1_valid & s1_hit & (s1_tid == IDX_W'(t));
    assign nxt_c = upd_c ? merge(acc_q, s1_elem, CORR_MAX) : acc_q;

    always_ff @(posedge clk) begin
      if (rst || close_c) acc_q <= PART_EMPTY;
      else                acc_q <= nxt_c;
      if (rst)          bank_q <= PART_EMPTY;
      else if (close_c) bank_q <= nxt_c;
    end
    assign bank_o[t] = bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bank_load <= 1'b0;
    else     bank_load <= close_c;
  end
endmodule

// File: rtl/psc_reduce.sv
module psc_reduce
  import psc_pkg::*;
#(
  parameter int THREADS       = 4,
  parameter int unsigned CORR_MAX = 8,
  localparam int IDX_W        = $clog2(THREADS)
) (
  input  logic   clk,
  input  logic   rst,
  input  part_t  bank_i [THREADS],
  input  logic   bank_load,
  input  logic   chain_valid,
  input  part_t  chain_part,
  output logic   busy,
  output logic   done,
  output part_t  res
);
  typedef enum logic [1:0] {ST_IDLE, ST_FOLD, ST_CHAIN} st_t;
  st_t              st;
  logic [IDX_W-1:0] idx;
  part_t            red, hold;
  logic             hold_full;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      red       <= PART_EMPTY;
      hold      <= PART_EMPTY;
      hold_full <= 1'b0;
      done      <= 1'b0;
      res       <= PART_EMPTY;
    end else begin
      done <= 1'b0;
      if (chain_valid) begin
        hold      <= chain_part;
        hold_full <= 1'b1;
      end
      case (st)
        ST_IDLE: if (bank_load) begin
          red <= bank_i[0];
          idx <= IDX_W'(1);
          st  <= ST_FOLD;
        end
        ST_FOLD: begin
          red <= merge(red, bank_i[idx], CORR_MAX);
          if (idx == IDX_W'(THREADS-1)) st <= ST_CHAIN;
          else                          idx <= idx + IDX_W'(1);
        end
        ST_CHAIN: if (hold_full) begin
          res       <= merge(red, hold, CORR_MAX);
          done      <= 1'b1;
          hold_full <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: the bank is only refilled once the previous reduction has finished
  p_load_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    bank_load |-> st == ST_IDLE);
  // R6: the result is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: upstream never overwrites a partial that is still waiting
  p_chain_no_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    chain_valid |-> !hold_full);
  // R4: the log-domain sum dominates the maximum
  p_score_dominates_r4: assert property (@(posedge clk) disable iff (rst)
    (done && res.full) |-> (res.osc >= res.gsc));
endmodule

// File: rtl/parent_score_core.sv
module parent_score_core
  import psc_pkg::*;
#(
  parameter int THREADS       = 4,
  parameter int unsigned CORR_MAX = 8,
  localparam int IDX_W        = $clog2(THREADS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MASK_W-1:0]   order_mask,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_last,
  input  logic [MASK_W-1:0]   in_parents,
  input  logic [SCORE_W-1:0]  in_score,
  input  logic                chain_in_valid,
  input  logic                chain_in_empty,
  input  logic [SCORE_W-1:0]  chain_in_order,
  input  logic [SCORE_W-1:0]  chain_in_graph,
  input  logic [MASK_W-1:0]   chain_in_parents,
  output logic                out_done,
  output logic                out_empty,
  output logic [SCORE_W-1:0]  out_order,
  output logic [SCORE_W-1:0]  out_graph,
  output logic [MASK_W-1:0]   out_parents
);
  logic             active;
  mask_t            order_q;
  logic [IDX_W-1:0] cnt;
  logic             take, busy_all, red_busy, bank_load;
  logic             s1_valid, s1_hit, s1_last;
  logic [IDX_W-1:0] s1_tid;
  part_t            s1_elem, res, chain_part;
  part_t            bank [THREADS];

  assign busy_all = (s1_valid & s1_last) | bank_load | red_busy;
  assign in_ready = active & ~(in_last & busy_all);
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      order_q <= '0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= '0;
      order_q <= order_mask;
    end else if (take) begin
      cnt <= (cnt == IDX_W'(THREADS-1)) ? '0 : cnt + IDX_W'(1);
      if (in_last) active <= 1'b0;
    end
  end

  psc_filter #(.THREADS(THREADS)) u_filter (
    .clk(clk), .rst(rst), .order_q(order_q), .take(take), .last(in_last),
    .parents(in_parents), .score(in_score), .tid(cnt),
    .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_last(s1_last),
    .s1_tid(s1_tid), .s1_elem(s1_elem)
  );

  psc_threads #(.THREADS(THREADS), .CORR_MAX(CORR_MAX)) u_threads (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_hit(s1_hit),
    .s1_last(s1_last), .s1_tid(s1_tid), .s1_elem(s1_elem),
    .bank_o(bank), .bank_load(bank_load)
  );

  assign chain_part = '{full: ~chain_in_empty, osc: chain_in_order,
                        gsc: chain_in_graph, pm: chain_in_parents};

  psc_reduce #(.THREADS(THREADS), .CORR_MAX(CORR_MAX)) u_reduce (
    .clk(clk), .rst(rst), .bank_i(bank), .bank_load(bank_load),
    .chain_valid(chain_in_valid), .chain_part(chain_part),
    .busy(red_busy), .done(out_done), .res(res)
  );

  assign out_empty   = ~res.full;
  assign out_order   = res.osc;
  assign out_graph   = res.gsc;
  assign out_parents = res.pm;

  // R5: every accepted candidate enters the scoring stage on the next cycle
  p_accept_reaches_stage_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_valid);
endmodule

// File: tb/parent_score_core_bench.sv
module parent_score_core_bench;
  localparam int CLK_NS = 10;
  localparam int T      = 4;
  localparam int CM     = 8;

  typedef struct {
    bit              full;
    int              os;
    int              gs;
    longint unsigned pm;
  } bpart_t;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [63:0] order_mask = '0, in_parents = '0, chain_in_parents = '0;
  logic [15:0] in_score = '0, chain_in_order = '0, chain_in_graph = '0;
  logic chain_in_valid = 1'b0, chain_in_empty = 1'b1;
  logic in_ready, out_done, out_empty;
  logic [15:0] out_order, out_graph;
  logic [63:0] out_parents;

  parent_score_core #(.THREADS(T), .CORR_MAX(CM)) u_parent_score_core (
    .clk(clk), .rst(rst), .start(start), .order_mask(order_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_parents(in_parents), .in_score(in_score),
    .chain_in_valid(chain_in_valid), .chain_in_empty(chain_in_empty),
    .chain_in_order(chain_in_order), .chain_in_graph(chain_in_graph),
    .chain_in_parents(chain_in_parents),
    .out_done(out_done), .out_empty(out_empty), .out_order(out_order),
    .out_graph(out_graph), .out_parents(out_parents)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0, done_cyc = 0, acc_cyc = 0;
  int first_acc_cyc = 0;
  bit stall_first = 0, stall_any = 0;
  bpart_t exq[$];
  bpart_t last_res;
  longint unsigned el_m[64];
  int el_s[64];
  int el_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bpart_t bmerge(bpart_t a, bpart_t b);
    bpart_t r;
    int d, c;
    if (!b.full) return a;
    if (!a.full) return b;
    d = (a.os > b.os) ? a.os - b.os : b.os - a.os;
    c = (d >= 2*CM) ? 0 : CM - d/2;
    r.full = 1;
    r.os = ((a.os >= b.os) ? a.os : b.os) + c;
    if (b.gs > a.gs) begin r.gs = b.gs; r.pm = b.pm; end
    else             begin r.gs = a.gs; r.pm = a.pm; end
    return r;
  endfunction

  function automatic bpart_t model(longint unsigned ord, bpart_t ch);
    bpart_t thr[T];
    bpart_t r, e;
    for (int t = 0; t < T; t++) thr[t] = '{0, 0, 0, 0};
    for (int i = 0; i < el_n; i++)
      if ((el_m[i] & ~ord) == 0) begin
        e = '{1, el_s[i], el_s[i], el_m[i]};
        thr[i % T] = bmerge(thr[i % T], e);
      end
    r = '{0, 0, 0, 0};
    for (int t = 0; t < T; t++) r = bmerge(r, thr[t]);
    return bmerge(r, ch);
  endfunction

  // result monitor, compared at every falling edge
  always @(negedge clk) begin
    if (out_done) begin
      done_cnt++;
      done_cyc = cyc;
      last_res = '{!out_empty, int'($signed(out_order)), int'($signed(out_graph)), out_parents};
      if (exq.size() == 0) chk(0, "R6", "unexpected done", 1, 0);
      else begin
        bpart_t e;
        e = exq.pop_front();
        chk(out_empty == !e.full, "R2", "empty flag", longint'(out_empty), longint'(!e.full));
        if (e.full) begin
          chk(int'($signed(out_order)) == e.os, "R3", "order score", $signed(out_order), e.os);
          chk(int'($signed(out_graph)) == e.gs, "R4", "graph score", $signed(out_graph), e.gs);
          chk(out_parents == e.pm, "R4", "best parents", out_parents, e.pm);
        end
      end
    end
    if (cyc > 20000) begin
      chk(0, "R6", "watchdog", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic add(input longint unsigned m, input int s);
    el_m[el_n] = m; el_s[el_n] = s; el_n++;
  endtask

  task automatic send_chain(input bpart_t p);
    @(negedge clk);
    chain_in_valid = 1; chain_in_empty = !p.full;
    chain_in_order = 16'(p.os); chain_in_graph = 16'(p.gs); chain_in_parents = p.pm;
    @(negedge clk);
    chain_in_valid = 0;
  endtask

  task automatic open_order(input longint unsigned ord, input bpart_t ch);
    exq.push_back(model(ord, ch));
    start = 1; order_mask = ord;
    @(negedge clk);
    start = 0;
  endtask

  task automatic stream();
    stall_first = 0; stall_any = 0;
    for (int i = 0; i < el_n; i++) begin
      in_valid = 1; in_parents = el_m[i]; in_score = 16'(el_s[i]);
      in_last = (i == el_n - 1);
      #1;
      while (!in_ready) begin
        if (i == 0) stall_first = 1;
        stall_any = 1;
        @(negedge clk); #1;
      end
      @(negedge clk);
      acc_cyc = cyc;
      if (i == 0) first_acc_cyc = cyc;
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  bpart_t none, up;
  int a_last, a_done;

  initial begin
    none = '{0, 0, 0, 0};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 0, "R10", "ready after reset", in_ready, 0);
    chk(out_done == 0, "R10", "done after reset", out_done, 0);

    // R1 R3: mixed order, strong incompatible candidates interleaved
    el_n = 0;
    add(64'h01, -40); add(64'h100, -5); add(64'h03, -42); add(64'h0F, -60);
    add(64'h200, -1); add(64'h05, -38); add(64'h02, -41); add(64'h80, -50);
    add(64'h81, -39); add(64'h00, -70);
    send_chain(none);
    open_order(64'hFF, none);
    stream();
    wait_done(1);
    chk(last_res.pm == 64'h05, "R1", "incompatible ignored", last_res.pm, 64'h05);

    // R2: nothing counts, empty upstream
    el_n = 0;
    add(64'h10, -3); add(64'h30, -4); add(64'h400, -2);
    send_chain(none);
    open_order(64'h0F, none);
    stream();
    wait_done(2);
    chk(last_res.full == 0, "R2", "empty result", last_res.full, 0);

    // R9: nothing counts locally, upstream partial passes through
    up = '{1, -20, -25, 64'h1234};
    send_chain(up);
    open_order(64'h0F, up);
    stream();
    wait_done(3);
    chk(last_res.pm == 64'h1234, "R9", "chain passes", last_res.pm, 64'h1234);

    // R5 R6 R9: back-to-back stream, chain already held, latency
    el_n = 0;
    for (int i = 0; i < 8; i++) add(64'(1) << i, -30 - 3*i);
    up = '{1, -28, -33, 64'h8000};
    send_chain(up);
    open_order(64'hFFFF, up);
    stream();
    chk(stall_any == 0, "R5", "ready held during stream", stall_any, 0);
    chk(acc_cyc - first_acc_cyc == 7, "R5", "one per clock", acc_cyc - first_acc_cyc, 7);
    a_last = acc_cyc;
    wait_done(4);
    chk(done_cyc - a_last == T + 2, "R6", "done latency", done_cyc - a_last, T + 2);

    // R7: next order scored while the previous one reduces
    el_n = 0;
    add(64'h1, -10); add(64'h2, -12); add(64'h4, -14); add(64'h8, -9); add(64'h3, -11);
    send_chain(none);
    open_order(64'hF, none);
    stream();
    el_n = 0;
    add(64'h6, -15); add(64'h1, -8); add(64'h7, -13);
    open_order(64'h7, none);
    stream();
    wait_done(5);
    a_done = done_cyc;
    chk(first_acc_cyc < a_done, "R7", "overlap accept before done", first_acc_cyc, a_done);
    send_chain(none);
    wait_done(6);

    // R8: single last candidate right after an order must stall
    el_n = 0;
    add(64'h1, -21); add(64'h2, -22);
    send_chain(none);
    open_order(64'h3, none);
    stream();
    el_n = 0;
    add(64'h2, -17);
    open_order(64'h3, none);
    stream();
    chk(stall_first == 1, "R8", "last held off", stall_first, 1);
    wait_done(7);
    send_chain(none);
    wait_done(8);

    // R4: ties keep the earlier merge (thread 0 over thread 1, index 0 over 4)
    el_n = 0;
    add(64'h1, -30); add(64'h2, -30); add(64'h8, -90); add(64'h8, -90); add(64'h4, -30);
    send_chain(none);
    open_order(64'hFF, none);
    stream();
    wait_done(9);
    chk(last_res.pm == 64'h1, "R4", "tie keeps earlier", last_res.pm, 64'h1);

    repeat (3) @(negedge clk);
    chk(exq.size() == 0, "R6", "all results seen", exq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule